// File: doc/BRIEF.md
# Float32 to packed 11/11/10 small-float encoder

This block converts three single-precision colour components into one 32-bit word of unsigned small floats. The red and green channels become 11-bit floats and the blue channel becomes a 10-bit float. Each channel is converted on its own. Negative values are clamped to zero and the exponent is re-biased. Extra mantissa bits are truncated. Overflow saturates to the largest finite code. Infinity and NaN map to fixed codes. Results that are too small for a normal small float become small-float denormals.

A producer presents the three words with `in_valid`. The packed word appears on `out_word` one cycle later, qualified by `out_valid`. When no input is valid, the output register keeps its last value.

Top module: `sf_r11g11b10_pack`

## Requirements
- R1: Red is placed in out_word[10:0], green in out_word[21:11] and blue in out_word[31:22].
- R2: Each small float is {exponent[4:0], mantissa}, with bias 15 and an implied leading one. Red and green have 6 mantissa bits and blue has 5. A positive normal input keeps its top mantissa bits and drops the rest (rounding toward zero).
- R3: A positive finite input above the largest representable value encodes as exponent 11110 with every mantissa bit set (0x7BF for red and green, 0x3DF for blue). It never encodes as infinity.
- R4: +Inf encodes as exponent 11111 with a zero mantissa (0x7C0 for red and green, 0x3E0 for blue). An exponent field of 11111 only ever carries a mantissa of zero or only its top bit set.
- R5: Negative finite inputs and -Inf encode as 0.
- R6: A NaN of either sign, signalling or quiet, encodes as exponent 11111 with only the top mantissa bit set (0x7E0 for red and green, 0x3F0 for blue).
- R7: A positive input below the smallest normal small float (2^-14) encodes with exponent 0. Its mantissa is the value divided by 2^-14, scaled by 2^M (where M is the channel's mantissa width) and truncated.
- R8: Positive zero, negative zero and single-precision denormal inputs encode as 0.
- R9: out_valid equals in_valid delayed by one cycle. out_word updates only in the cycle after a valid input and holds its value otherwise.
- R10: While reset is asserted, out_valid and out_word are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input words are valid this cycle |
| in_red | input | 32 | Red component, single precision |
| in_green | input | 32 | Green component, single precision |
| in_blue | input | 32 | Blue component, single precision |
| out_valid | output | 1 | out_word carries a new result |
| out_word | output | 32 | Packed blue/green/red small floats |

## Verification
The properties assume that `in_valid` is low while reset is held and that the three input words carry no unknown bits whenever `in_valid` is high. The input-to-output properties also assume the default channel widths. The stimulus keeps `in_valid` low through reset and drives fully defined words at every valid beat. It mixes directed edge values with random words that are weighted towards the all-ones exponent, the zero exponent and the denormal-to-saturation band. Idle gaps are inserted at random so that the hold behaviour is exercised.

// File: rtl/sf_pack_pkg.sv
package sf_pack_pkg;

  localparam int F32_W      = 32;
  localparam int F32_EXP_W  = 8;
  localparam int F32_FRAC_W = 23;
  localparam int F32_BIAS   = 127;

  typedef enum logic [2:0] {
    F_ZERO,
    F_NEG,
    F_FIN,
    F_INF,
    F_NAN
  } f32_kind_e;

endpackage

// File: rtl/sf_f32_classify.sv
module sf_f32_classify
  import sf_pack_pkg::*;
(
  input  logic [F32_W-1:0]      value_i,
  output f32_kind_e             kind_o,
  output logic [F32_EXP_W-1:0]  exp_o,
  output logic [F32_FRAC_W-1:0] frac_o
);

  logic sign;
  logic exp_all_ones;
  logic exp_zero;
  logic frac_zero;

  always_comb begin
    sign         = value_i[F32_W-1];
    exp_o        = value_i[F32_W-2 -: F32_EXP_W];
    frac_o       = value_i[F32_FRAC_W-1:0];
    exp_all_ones = &exp_o;
    exp_zero     = ~|exp_o;
    frac_zero    = ~|frac_o;
  end

  // Negative zero and input denormals fold into the zero or negative classes.
  always_comb begin
    if (exp_all_ones) begin
      if (!frac_zero) begin
        kind_o = F_NAN;
      end else if (sign) begin
        kind_o = F_NEG;
      end else begin
        kind_o = F_INF;
      end
    end else if (sign) begin
      kind_o = F_NEG;
    end else if (exp_zero) begin
      kind_o = F_ZERO;
    end else begin
      kind_o = F_FIN;
    end
  end

endmodule

// File: rtl/sf_chan_enc.sv
module sf_chan_enc
  import sf_pack_pkg::*;
#(
  parameter int MANT_W = 6,
  parameter int EXP_W  = 5
) (
  input  logic [F32_W-1:0]        value_i,
  output logic [MANT_W+EXP_W-1:0] code_o
);

  localparam int SMALL_BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int REBIAS      = F32_BIAS - SMALL_BIAS;
  localparam int TOP_FIN_EXP = (1 << EXP_W) - 2;

  localparam logic [F32_EXP_W-1:0] REBIAS_E  = F32_EXP_W'(REBIAS);
  localparam logic [F32_EXP_W-1:0] SAT_ABOVE = F32_EXP_W'(REBIAS + TOP_FIN_EXP);
  localparam logic [F32_EXP_W:0]   DEN_BASE  = (F32_EXP_W + 1)'(F32_FRAC_W - MANT_W + REBIAS + 1);

  localparam logic [MANT_W+EXP_W-1:0] CODE_NAN =
    {{EXP_W{1'b1}}, 1'b1, {(MANT_W-1){1'b0}}};
  localparam logic [MANT_W+EXP_W-1:0] CODE_INF =
    {{EXP_W{1'b1}}, {MANT_W{1'b0}}};
  localparam logic [MANT_W+EXP_W-1:0] CODE_SAT =
    {{(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};

  f32_kind_e              kind;
  logic [F32_EXP_W-1:0]   exp8;
  logic [F32_FRAC_W-1:0]  frac;
  logic [EXP_W-1:0]       norm_exp;
  logic [F32_EXP_W:0]     den_shamt;
  logic [F32_FRAC_W:0]    significand;
  logic [MANT_W-1:0]      den_mant;

  sf_f32_classify u_class (
    .value_i (value_i),
    .kind_o  (kind),
    .exp_o   (exp8),
    .frac_o  (frac)
  );

  always_comb begin
    norm_exp    = EXP_W'(exp8 - REBIAS_E);
    significand = {1'b1, frac};
    // Exponents at or below the rebias point shift the significand right.
    den_shamt   = DEN_BASE - {1'b0, exp8};
    den_mant    = MANT_W'(significand >> den_shamt);
  end

  always_comb begin
    code_o = '0;
    unique case (kind)
      F_NAN:  code_o = CODE_NAN;
      F_INF:  code_o = CODE_INF;
      F_FIN: begin
        if (exp8 > SAT_ABOVE) begin
          code_o = CODE_SAT;
        end else if (exp8 > REBIAS_E) begin
          code_o = {norm_exp, frac[F32_FRAC_W-1 -: MANT_W]};
        end else begin
          code_o = {{EXP_W{1'b0}}, den_mant};
        end
      end
      default: code_o = '0;
    endcase
  end

endmodule

// File: rtl/sf_out_stage.sv
module sf_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_nxt;
  logic         valid_nxt;

  always_comb begin
    valid_nxt = en_i;
    q_nxt     = q_o;
    if (en_i) begin
      q_nxt = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      q_o     <= q_nxt;
      valid_o <= valid_nxt;
    end
  end

endmodule

// File: rtl/sf_r11g11b10_pack.sv
module sf_r11g11b10_pack
  import sf_pack_pkg::*;
#(
  parameter  int RG_MANT_W = 6,
  parameter  int B_MANT_W  = 5,
  parameter  int EXP_W     = 5,
  localparam int RG_CODE_W = RG_MANT_W + EXP_W,
  localparam int PACK_W    = 2 * RG_CODE_W + B_MANT_W + EXP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [F32_W-1:0]  in_red,
  input  logic [F32_W-1:0]  in_green,
  input  logic [F32_W-1:0]  in_blue,
  output logic              out_valid,
  output logic [PACK_W-1:0] out_word
);

  localparam int N_CHAN = 3;

  logic [F32_W-1:0]  chan_in [N_CHAN];
  logic [PACK_W-1:0] packed_word;

  assign chan_in[0] = in_red;
  assign chan_in[1] = in_green;
  assign chan_in[2] = in_blue;

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    localparam int MW  = (ch == N_CHAN - 1) ? B_MANT_W : RG_MANT_W;
    localparam int LSB = ch * RG_CODE_W;

    logic [MW+EXP_W-1:0] code;

    sf_chan_enc #(
      .MANT_W (MW),
      .EXP_W  (EXP_W)
    ) u_enc (
      .value_i (chan_in[ch]),
      .code_o  (code)
    );

    assign packed_word[LSB +: MW+EXP_W] = code;
  end

  sf_out_stage #(
    .W (PACK_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (in_valid),
    .d_i     (packed_word),
    .valid_o (out_valid),
    .q_o     (out_word)
  );

endmodule

// File: rtl/sf_pack_checker.sv
module sf_pack_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_red,
  input logic [31:0] in_green,
  input logic [31:0] in_blue,
  input logic        out_valid,
  input logic [31:0] out_word
);

  logic armed;
  logic red_nan;
  logic blue_nan;
  logic green_big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    red_nan   = (&in_red[30:23]) && (|in_red[22:0]);
    blue_nan  = (&in_blue[30:23]) && (|in_blue[22:0]);
    green_big = !in_green[31] && (in_green[30:23] >= 8'd143) && !(&in_green[30:23]);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_valid && out_word == 32'h0);  // R10

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_valid == $past(in_valid));  // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(in_valid) |-> $stable(out_word));  // R9

  AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_red[31] && !red_nan |=> out_word[10:0] == 11'h000);  // R5

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && blue_nan |=> out_word[31:22] == 10'h3F0);  // R6

  AST_SAT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && green_big |=> out_word[21:11] == 11'h7BF);  // R3

  AST_TOP_EXP_MANT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[10:6] == 5'h1F |-> out_word[5:0] == 6'h00 || out_word[5:0] == 6'h20);  // R4

endmodule

bind sf_r11g11b10_pack sf_pack_checker i_sf_pack_checker (.*);

// File: tb/test_sf_r11g11b10_pack.sv
`timescale 1ns/1ps
module test_sf_r11g11b10_pack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_red = '0;
  logic [31:0] in_green = '0;
  logic [31:0] in_blue = '0;
  logic        out_valid;
  logic [31:0] out_word;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_word = '0;

  always #2 clk = ~clk;

  sf_r11g11b10_pack i_sf_r11g11b10_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_red    (in_red),
    .in_green  (in_green),
    .in_blue   (in_blue),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  // Reference: value expressed in units of the smallest denormal step, then re-encoded.
  function automatic logic [10:0] enc(input logic [31:0] f, input int mw);
    logic [7:0]      e8;
    longint unsigned sig;
    longint unsigned val;
    int              sh;
    logic [10:0]     sat;
    e8  = f[30:23];
    sat = 11'((30 << mw) | ((1 << mw) - 1));
    if (e8 == 8'hFF) begin
      if (f[22:0] != 0) return 11'((31 << mw) | (1 << (mw - 1)));
      return f[31] ? 11'h0 : 11'(31 << mw);
    end
    if (f[31] || e8 == 0) return 11'h0;
    sig = {40'd0, 1'b1, f[22:0]};
    sh  = int'(e8) - 136 + mw;
    if (sh > 40) return sat;
    val = (sh >= 0) ? (sig << sh) : (sig >> (-sh));
    if (val >= (64'd1 << (mw + 30))) return sat;
    if (val < (64'd1 << mw)) return 11'(val);
    for (int e = 1; e <= 30; e++) begin
      if (val < (64'd1 << (mw + e)))
        return 11'((e << mw) | ((val >> (e - 1)) & ((64'd1 << mw) - 1)));
    end
    return 11'h0;
  endfunction

  function automatic logic [31:0] pack_ref(input logic [31:0] r, input logic [31:0] g,
                                           input logic [31:0] b);
    logic [10:0] rc;
    logic [10:0] gc;
    logic [10:0] bc;
    rc = enc(r, 6);
    gc = enc(g, 6);
    bc = enc(b, 5);
    return {bc[9:0], gc, rc};
  endfunction

  function automatic logic [31:0] rnd_word();
    logic [31:0] w;
    int          sel;
    w   = $urandom;
    sel = $urandom_range(0, 5);
    case (sel)
      0, 1: w[30:23] = 8'(100 + $urandom_range(0, 50));
      2:    w[30:23] = 8'hFF;
      3:    w[30:23] = 8'h00;
      default: ;
    endcase
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] r, input logic [31:0] g, input logic [31:0] b,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_red   = r;
    in_green = g;
    in_blue  = b;
    exp_q.push_back(pack_ref(r, g, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_red   = $urandom;
      in_green = $urandom;
      in_blue  = $urandom;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: compares every result with the scoreboard, and checks hold on idle cycles.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected out_valid", {31'd0, out_valid}, 32'h0);
        end else begin
          logic [31:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word === e, t, out_word, e);
          last_word = out_word;
        end
      end else begin
        check(out_word === last_word, "R9 hold while idle", out_word, last_word);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'h0);
    check(out_word === 32'h0, "R10 reset out_word", out_word, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 field placement
    send(32'h3F800000, 32'h00000000, 32'h00000000, "R1 red field");
    send(32'h00000000, 32'h3F800000, 32'h00000000, "R1 green field");
    send(32'h00000000, 32'h00000000, 32'h3F800000, "R1 blue field");
    check(pack_ref(32'h3F800000, 0, 0) == 32'h000003C0, "R1 model red 1.0",
          pack_ref(32'h3F800000, 0, 0), 32'h000003C0);
    // R2 normal values and truncation
    send(32'h3FC00000, 32'h3F8FFFFF, 32'h4048F5C3, "R2 normal truncation");
    send(32'h477E0000, 32'h3E800000, 32'h477C0000, "R2 largest finite exact");
    // R3 saturation
    send(32'h47800000, 32'h7F7FFFFF, 32'h47800000, "R3 overflow saturates");
    check(pack_ref(32'h47800000, 0, 32'h7F7FFFFF) == {10'h3DF, 11'h0, 11'h7BF},
          "R3 model saturation codes", pack_ref(32'h47800000, 0, 32'h7F7FFFFF),
          {10'h3DF, 11'h0, 11'h7BF});
    // R4 +Inf
    send(32'h7F800000, 32'h7F800000, 32'h7F800000, "R4 positive infinity");
    // R5 negative values
    send(32'hFF800000, 32'hBF800000, 32'hC2000000, "R5 negative to zero");
    // R6 NaN
    send(32'h7FC00000, 32'hFFC00000, 32'h7F800001, "R6 NaN quiet code");
    check(pack_ref(32'h7FC00000, 0, 32'h7F800001) == {10'h3F0, 11'h0, 11'h7E0},
          "R6 model NaN codes", pack_ref(32'h7FC00000, 0, 32'h7F800001),
          {10'h3F0, 11'h0, 11'h7E0});
    // R7 denormal outputs
    send(32'h38000000, 32'h35800000, 32'h387FFFFF, "R7 denormal output");
    send(32'h35000000, 32'h37FFFFFF, 32'h36000000, "R7 denormal truncation");
    check(pack_ref(32'h38000000, 32'h35800000, 0) == {10'h0, 11'h001, 11'h020},
          "R7 model denormal codes", pack_ref(32'h38000000, 32'h35800000, 0),
          {10'h0, 11'h001, 11'h020});
    // R8 zeros and input denormals
    send(32'h80000000, 32'h00000001, 32'h007FFFFF, "R8 zero and input denormal");
    idle(3);

    // R9 back-to-back and gapped traffic, mixed values
    for (int i = 0; i < 400; i++) begin
      send(rnd_word(), rnd_word(), rnd_word(), "R2 mixed stream");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(1);

    for (int i = 0; i < 20 && exp_q.size() != 0; i++) idle(1);
    check(exp_q.size() == 0, "R9 all results delivered", 32'(exp_q.size()), 32'h0);
    idle(3);
    summary();
    $finish;
  end

endmodule